// File: doc/BRIEF.md
# Buffered 16-bit Timer with Byte-Wide Register Access

A 16-bit up-counter driven by a qualified tick input through a power-of-two prescaler. Software reaches it over an 8-bit register port that has one address for the low byte, one for the high byte and one for control. Because the counter keeps running while software touches it one byte at a time, a wide mode routes the high-byte address to a shadow byte. A low-byte read snapshots the high byte, and a low-byte write commits the shadow into the high byte. Software therefore always sees, and always loads, a coherent 16-bit value.

With wide mode off, both byte addresses reach the counter directly. A sticky overflow flag records each wrap from all ones to zero, and software clears it by writing one to it. The tick input is a plain synchronous enable. Clock sourcing, oscillators and interrupt routing are outside the block.

Top module: `tmr16_regs`

## Requirements
- R1: Address 0 is the low byte, address 1 the high byte, address 2 control, and address 3 reads as zero. The control byte layout is: bit0 run, bit1 wide mode, bits5:4 prescale select, bit7 overflow flag. All of these reset to zero, and so do the counter and the shadow.
- R2: In wide mode, a read of address 0 returns the counter low byte, and the same clock edge copies the counter high byte into the shadow.
- R3: In wide mode, a read of address 1 returns the shadow, so it matches the earlier low-byte read even if the counter carried in between.
- R4: In wide mode, a write to address 1 changes only the shadow and leaves the counter high byte as it was.
- R5: In wide mode, a write to address 0 loads the written byte into the low byte and the shadow into the high byte on one edge.
- R6: With wide mode off, address 1 reads and writes the counter high byte directly and the shadow is untouched. A write to address 0 changes only the low byte.
- R7: A write to address 0 clears the prescaler. Writes to address 1 or 2 never clear it.
- R8: The counter advances once per 2^sel qualifying ticks (sel = bits5:4). A tick qualifies only when tick_en is high and run is set. Otherwise counter and prescaler hold.
- R9: A counter wrap from 0xFFFF to 0x0000 sets the overflow flag, which stays set until a control write with bit7 = 1. If a wrap and such a clear happen on the same edge, the flag stays set.
- R10: A byte write on the same edge as an increment wins. After a low-byte write the next increment comes a full prescale period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counting input enable, one tick per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench reads the low byte in the same cycle as a carry into the high byte. A design that latched the high byte one edge late would then return a torn value through the shadow. It parks a value in the shadow and inspects the counter through the direct path, which exposes a high-byte write that leaks straight into the counter. It interleaves high-byte and control writes between prescaled ticks, so a design that cleared the prescaler on those writes would show shifted increments. It also lines up a wrap with a flag-clear write, where a clear-priority design would lose the overflow.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam logic [1:0] ADR_LO  = 2'd0;
  localparam logic [1:0] ADR_HI  = 2'd1;
  localparam logic [1:0] ADR_CTL = 2'd2;

  localparam int CB_RUN  = 0;
  localparam int CB_WIDE = 1;
  localparam int CB_SEL  = 4;
  localparam int CB_OVF  = 7;

  // Control byte image from its fields.
  function automatic logic [7:0] ctl_image(input logic run, input logic wide,
                                           input logic [1:0] sel, input logic ovf);
    logic [7:0] v;
    v = '0;
    v[CB_RUN]  = run;
    v[CB_WIDE] = wide;
    v[CB_SEL +: 2] = sel;
    v[CB_OVF]  = ovf;
    return v;
  endfunction
endpackage

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             fire
);
  localparam int PS_W = (1 << SEL_W) - 1;

  logic [PS_W-1:0] ps_cnt;
  logic [PS_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PS_W; i++) mask[i] = (i < int'(sel));
  end

  assign fire = en && !clr && ((ps_cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)   ps_cnt <= '0;
    else if (clr) ps_cnt <= '0;
    else if (en)  ps_cnt <= ps_cnt + 1'b1;
  end

  // R7: a low-byte write leaves the prescaler at zero
  assert_ps_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ps_cnt == '0);
  // R8: no qualifying tick, no prescaler motion
  assert_ps_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(ps_cnt));
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_lo,
  input  logic                ld_hi,
  input  logic [BYTE_W-1:0]   lo_val,
  input  logic [BYTE_W-1:0]   hi_val,
  input  logic                inc,
  output logic [2*BYTE_W-1:0] cnt,
  output logic                wrap
);
  localparam int CNT_W = 2 * BYTE_W;

  logic ld_any;
  assign ld_any = ld_lo || ld_hi;
  assign wrap   = inc && !ld_any && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (ld_any) begin
      if (ld_lo) cnt[BYTE_W-1:0]     <= lo_val;
      if (ld_hi) cnt[CNT_W-1:BYTE_W] <= hi_val;
    end else if (inc) cnt <= cnt + 1'b1;
  end

  // R8: a bare increment steps by one
  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_any) |=> cnt == CNT_W'($past(cnt) + 1'b1));
  // R10: a load on an increment edge takes the written value
  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_lo && inc) |=> cnt[BYTE_W-1:0] == $past(lo_val));
endmodule

// File: rtl/tmr16_shadow.sv
module tmr16_shadow #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snap,
  input  logic [BYTE_W-1:0] snap_val,
  input  logic              put,
  input  logic [BYTE_W-1:0] put_val,
  output logic [BYTE_W-1:0] shadow
);
  always_ff @(posedge clk) begin
    if (!rst_n)    shadow <= '0;
    else if (snap) shadow <= snap_val;
    else if (put)  shadow <= put_val;
  end
endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              ovf_flag
);
  localparam int CNT_W = 2 * BYTE_W;

  logic             run, wide, ovf;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] cnt;
  logic [BYTE_W-1:0] shadow, hi_val;
  logic wr_lo, wr_hi, wr_ctl, rd_lo, ld_hi, fire, wrap;

  assign wr_lo  = bus_wr && (bus_addr == ADR_LO);
  assign wr_hi  = bus_wr && (bus_addr == ADR_HI);
  assign wr_ctl = bus_wr && (bus_addr == ADR_CTL);
  assign rd_lo  = bus_rd && (bus_addr == ADR_LO);
  assign ld_hi  = (wr_lo && wide) || (wr_hi && !wide);
  assign hi_val = wide ? shadow : bus_wdata;

  tmr16_prescaler #(.SEL_W(SEL_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .en(tick_en && run), .clr(wr_lo),
    .sel(sel), .fire(fire));

  tmr16_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld_lo(wr_lo), .ld_hi(ld_hi),
    .lo_val(bus_wdata), .hi_val(hi_val), .inc(fire), .cnt(cnt), .wrap(wrap));

  tmr16_shadow #(.BYTE_W(BYTE_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .snap(rd_lo && wide), .snap_val(cnt[CNT_W-1:BYTE_W]),
    .put(wr_hi && wide), .put_val(bus_wdata), .shadow(shadow));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; wide <= 1'b0; sel <= '0; ovf <= 1'b0;
    end else begin
      if (wr_ctl) begin
        run  <= bus_wdata[CB_RUN];
        wide <= bus_wdata[CB_WIDE];
        sel  <= bus_wdata[CB_SEL +: SEL_W];
      end
      if (wrap) ovf <= 1'b1;
      else if (wr_ctl && bus_wdata[CB_OVF]) ovf <= 1'b0;
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADR_LO:  bus_rdata = cnt[BYTE_W-1:0];
      ADR_HI:  bus_rdata = wide ? shadow : cnt[CNT_W-1:BYTE_W];
      ADR_CTL: bus_rdata = BYTE_W'(ctl_image(run, wide, 2'(sel), ovf));
      default: bus_rdata = '0;
    endcase
  end

  assign ovf_flag = ovf;

  // R2: wide low read snapshots the high byte
  assert_lo_read_snap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && wide) |=> shadow == $past(cnt[CNT_W-1:BYTE_W]));
  // R4: wide high write does not reach the counter
  assert_hi_write_parked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && wide && !fire) |=> $stable(cnt));
  // R5: wide low write commits all 16 bits
  assert_lo_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && wide) |=> cnt == {$past(shadow), $past(bus_wdata)});
  // R9: a wrap always leaves the flag set
  assert_ovf_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag);
endmodule

// File: tb/tb_tmr16_regs.sv
`timescale 1ns/1ps
module tb_tmr16_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic ovf_flag;

  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  tmr16_regs dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ovf_flag(ovf_flag));

  // Reference state
  logic [15:0] m_cnt = '0;
  logic [7:0]  m_sh = '0;
  logic [2:0]  m_ps = '0;
  logic        m_run = 0, m_wide = 0, m_ovf = 0;
  logic [1:0]  m_sel = '0;

  localparam int IDLE = 0, RD = 1, WR = 2;

  task automatic chk(input string lbl, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", lbl, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_cnt[7:0];
      2'd1: return m_wide ? m_sh : m_cnt[15:8];
      2'd2: return {m_ovf, 1'b0, m_sel, 2'b00, m_wide, m_run};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_lbl(input logic [1:0] a);
    if (a == 2'd0) return "R2 low read";
    if (a == 2'd1) return m_wide ? "R3 shadow read" : "R6 direct high read";
    if (a == 2'd2) return "R9 control read";
    return "R1 spare address";
  endfunction

  // Divide-by-2^sel: due when the low sel bits of the prescale count are all ones
  function automatic logic ps_due(input logic [2:0] ps, input logic [1:0] sel);
    int span;
    span = 1 << sel;
    return ((int'(ps) % span) == span - 1);
  endfunction

  task automatic model_step(input int op, input logic [1:0] a, input logic [7:0] d, input logic t);
    logic wlo, whi, wct, rlo, en, inc, wrp;
    logic [15:0] c;
    wlo = (op == WR) && (a == 0);
    whi = (op == WR) && (a == 1);
    wct = (op == WR) && (a == 2);
    rlo = (op == RD) && (a == 0);
    en  = t && m_run;
    inc = en && !wlo && ps_due(m_ps, m_sel);
    c = m_cnt; wrp = 1'b0;
    if (wlo) c = {m_wide ? m_sh : m_cnt[15:8], d};
    else if (whi && !m_wide) c = {d, m_cnt[7:0]};
    else if (inc) begin wrp = (m_cnt == 16'hFFFF); c = m_cnt + 16'd1; end
    if (rlo && m_wide) m_sh = m_cnt[15:8];
    else if (whi && m_wide) m_sh = d;
    if (wlo) m_ps = '0; else if (en) m_ps = m_ps + 3'd1;
    if (wct && d[7]) m_ovf = 1'b0;
    if (wrp) m_ovf = 1'b1;
    if (wct) begin m_run = d[0]; m_wide = d[1]; m_sel = d[5:4]; end
    m_cnt = c;
  endtask

  task automatic cyc(input int op, input logic [1:0] a, input logic [7:0] d,
                     input logic t, input string lbl);
    @(negedge clk);
    chk("R9 flag", {7'd0, ovf_flag}, {7'd0, m_ovf});
    bus_rd = (op == RD); bus_wr = (op == WR);
    bus_addr = a; bus_wdata = d; tick_en = t;
    #1;
    if (op == RD) chk(lbl == "" ? rd_lbl(a) : lbl, bus_rdata, exp_rd(a));
    model_step(op, a, d, t);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values and map
    cyc(RD, 2, 0, 0, "R1 control reset");
    cyc(RD, 0, 0, 0, "R1 low reset");
    cyc(RD, 1, 0, 0, "R1 high reset");
    cyc(RD, 3, 0, 0, "R1 spare");
    // R8: divide by 4, run on, gated ticks
    cyc(WR, 2, 8'h21, 0, "");
    repeat (3) cyc(IDLE, 0, 0, 1, "");
    cyc(RD, 0, 0, 0, "R8 before fourth tick");
    cyc(IDLE, 0, 0, 1, "");
    cyc(RD, 0, 0, 0, "R8 after four ticks");
    repeat (3) cyc(IDLE, 0, 0, 0, "");
    cyc(RD, 0, 0, 0, "R8 gated ticks hold");
    // R7: high/control writes between ticks leave prescaler alone
    cyc(IDLE, 0, 0, 1, ""); cyc(IDLE, 0, 0, 1, "");
    cyc(WR, 1, 8'h40, 1, "");
    cyc(WR, 2, 8'h21, 1, "");
    cyc(RD, 0, 0, 0, "R7 no clear by high write");
    cyc(RD, 1, 0, 0, "R6 direct high write");
    // R4 / R5: wide mode, div 1
    cyc(WR, 2, 8'h03, 0, "");
    cyc(WR, 1, 8'hAB, 0, "");
    cyc(WR, 2, 8'h01, 0, "");
    cyc(RD, 1, 0, 0, "R4 counter high untouched");
    cyc(WR, 2, 8'h03, 0, "");
    cyc(WR, 0, 8'hCD, 0, "");
    cyc(WR, 2, 8'h01, 0, "");
    cyc(RD, 1, 0, 0, "R5 high committed");
    cyc(RD, 0, 0, 0, "R5 low committed");
    // R3: read low on the carry edge, then high from shadow
    cyc(WR, 2, 8'h03, 0, "");
    cyc(WR, 1, 8'h12, 0, "");
    cyc(WR, 0, 8'hFF, 0, "");
    cyc(RD, 0, 0, 1, "R2 low before carry");
    cyc(RD, 1, 0, 0, "R3 shadow holds pre-carry high");
    cyc(RD, 0, 0, 0, "R2 low after carry");
    // R10: low write on a tick edge wins, next tick counts
    cyc(WR, 0, 8'h50, 1, "");
    cyc(RD, 0, 0, 1, "R10 written value kept");
    cyc(RD, 0, 0, 0, "R10 resumes counting");
    // R9: wrap sets flag, clear works, clear on wrap edge loses
    cyc(WR, 1, 8'hFF, 0, ""); cyc(WR, 0, 8'hFF, 0, "");
    cyc(IDLE, 0, 0, 1, "");
    cyc(RD, 2, 0, 0, "R9 flag set by wrap");
    cyc(WR, 2, 8'h83, 0, "");
    cyc(RD, 2, 0, 0, "R9 flag cleared");
    cyc(WR, 0, 8'hFF, 0, "");
    cyc(WR, 2, 8'h83, 1, "");
    cyc(RD, 2, 0, 0, "R9 set beats clear");
    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int op; logic [1:0] a; logic [7:0] d;
      op = $urandom_range(0, 9);
      op = (op < 4) ? IDLE : (op < 7) ? RD : WR;
      a  = 2'($urandom_range(0, 3));
      d  = 8'($urandom);
      if (op == WR && a == 2) d[0] = ($urandom_range(0, 7) != 0);
      cyc(op, a, d, 1'($urandom_range(0, 3) != 0), "");
    end
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule